// File: doc/BRIEF.md
# Per-Thread Outstanding Address Tracker

This block sits at the front of a memory access port that several hardware threads share. Each thread has its own small list of addresses that are in flight. Every entry holds an address and the sequence number of the instruction that owns it. A new request names a thread, an address, a sequence number, and a flag that marks it as coming from the instruction-fetch side. In the same cycle the block answers with a grant or a denial.

A data request is refused when its thread already has an entry for exactly that address. The exception is the owner itself: an instruction that comes back for a replay is granted again. Fetch requests skip the address comparison but still need a free entry. A granted request that is not a replay is recorded.

Entries leave the list through a release port, which is used both for completions and for squashes. A release that finds no entry is reported as an error, unless it is flagged as the second half of a split access. Each thread also has a translation-stall flag. While that flag is set, every request from the thread is refused.

Top module: `addr_track_top`

## Requirements
- R1: A data request (fetch flag low) is denied when its thread holds a valid entry with an identical address and a different owner sequence number. The same address on another thread, and a different address on the same thread, are unaffected.
- R2: A data request whose address and sequence number both match an existing entry of its thread is granted. It adds no second entry, so a single release then empties that address.
- R3: A request with the fetch flag high is granted without an address comparison and is recorded on grant. A duplicate address therefore takes a second entry. It is still denied when no entry is free.
- R4: `blkSet` sets the stall flag of thread `blkThread` and `blkClr` clears it, both from the next cycle on. Set wins when both are high. While a thread's flag is set, all of its requests are denied with `reqOverflow` low, and other threads are unaffected. `blkState` bit n is the flag of thread n.
- R5: The grant is combinational in the request cycle. A granted non-replay request stores its address and sequence number at the next clock edge, and that entry blocks conflicting requests from the following cycle.
- R6: Each thread holds at most LIST_LIMIT-1 entries. A request that would need a new entry while its thread is full is denied, and `reqOverflow` is high in that cycle. A replay is still granted when the thread is full.
- R7: A release removes one entry of `relThread` whose address equals `relAddr`. When no entry matches, `relMissErr` is high in that cycle unless `relSplit2nd` is high.
- R8: A release and a request in the same cycle act as if the release came first. The released address is no longer a conflict, and the freed entry counts as free for that request.
- R9: Reset empties every list and clears every stall flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqThread | input | THREAD_W | Requesting thread |
| reqAddr | input | ADDR_W | Requested address |
| reqSeq | input | SEQ_W | Sequence number of the requester |
| reqFetch | input | 1 | Request comes from the instruction-fetch side |
| reqGrant | output | 1 | Request granted (combinational) |
| reqOverflow | output | 1 | Request denied because the thread list is full |
| relValid | input | 1 | Release present this cycle |
| relThread | input | THREAD_W | Thread of the release |
| relAddr | input | ADDR_W | Address to release |
| relSplit2nd | input | 1 | Release belongs to the second half of a split access |
| relMissErr | output | 1 | Release found no entry and was not a split second half |
| blkSet | input | 1 | Set the stall flag of blkThread |
| blkClr | input | 1 | Clear the stall flag of blkThread |
| blkThread | input | THREAD_W | Thread addressed by blkSet/blkClr |
| blkState | output | NUM_THREADS | Current stall flags, one per thread |

## Verification
The bench builds the block with two threads, LIST_LIMIT of 4, 16-bit addresses and 8-bit sequence numbers. At that size a thread fills after three grants, so the overflow denial, replay-while-full and the same-cycle release-and-request case can all be reached in a handful of cycles. With two threads, isolation can be shown directly: conflicts, stall flags and capacity on one thread leave the other untouched.

// File: rtl/addr_track_pkg.sv
package addr_track_pkg;

  // Strobes from control to the entry store.
  typedef struct packed {
    logic insEn;
    logic relEn;
  } trackStrb_t;

  // Search results from the entry store to control.
  typedef struct packed {
    logic conflict;
    logic ownerMatch;
    logic full;
    logic relHit;
  } trackLook_t;

  typedef enum logic [2:0] {
    DEC_IDLE,
    DEC_NEW,
    DEC_REPLAY,
    DEC_CONFLICT,
    DEC_BLOCKED,
    DEC_FULL
  } trackDec_e;

endpackage

// File: rtl/addr_track_store.sv
module addr_track_store
  import addr_track_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 9,
  parameter int ADDR_W      = 32,
  parameter int SEQ_W       = 16,
  parameter int THREAD_W    = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [THREAD_W-1:0] reqThread,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [SEQ_W-1:0]    reqSeq,
  input  logic                relValid,
  input  logic [THREAD_W-1:0] relThread,
  input  logic [ADDR_W-1:0]   relAddr,
  input  trackStrb_t          strb,
  output trackLook_t          look
);

  logic [NUM_THREADS-1:0][DEPTH-1:0] entV;
  logic [ADDR_W-1:0] entA [NUM_THREADS][DEPTH];
  logic [SEQ_W-1:0]  entS [NUM_THREADS][DEPTH];

  logic [DEPTH-1:0] relMatch, relPick;
  logic [DEPTH-1:0] effV, reqMatch, seqEq, freeVec, freePick;
  logic             sameThread;

  // Release search on its own thread; lowest matching entry is removed.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      relMatch[i] = entV[relThread][i] && (entA[relThread][i] == relAddr);
    end
    relPick = relMatch & (~relMatch + DEPTH'(1));
  end

  // Request search sees the list as it stands after this cycle's release.
  assign sameThread = relValid && (relThread == reqThread);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      effV[i]     = entV[reqThread][i] && !(sameThread && relPick[i]);
      reqMatch[i] = effV[i] && (entA[reqThread][i] == reqAddr);
      seqEq[i]    = (entS[reqThread][i] == reqSeq);
    end
    freeVec  = ~effV;
    freePick = freeVec & (~freeVec + DEPTH'(1));
  end

  assign look.conflict   = |reqMatch;
  assign look.ownerMatch = |(reqMatch & seqEq);
  assign look.full       = ~|freeVec;
  assign look.relHit     = |relMatch;

  // Storage: one flop group per thread and entry.
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic hitRel, hitIns;
      assign hitRel = strb.relEn && (relThread == THREAD_W'(t)) && relPick[i];
      assign hitIns = strb.insEn && (reqThread == THREAD_W'(t)) && freePick[i];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          entV[t][i] <= 1'b0;
        end else if (hitIns) begin
          entV[t][i] <= 1'b1;
        end else if (hitRel) begin
          entV[t][i] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (hitIns) begin
          entA[t][i] <= reqAddr;
          entS[t][i] <= reqSeq;
        end
      end
    end
  end

  AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.insEn |=> |(entV[$past(reqThread)] & $past(freePick))); // R5

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.relEn && !(strb.insEn && (reqThread == relThread) && |(freePick & relPick)))
      |=> !(|(entV[$past(relThread)] & $past(relPick)))); // R7

  AST_FULL_NO_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    look.full |-> !strb.insEn); // R6

endmodule

// File: rtl/addr_track_ctrl.sv
module addr_track_ctrl
  import addr_track_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int THREAD_W    = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [THREAD_W-1:0]    reqThread,
  input  logic                   reqFetch,
  input  logic                   relValid,
  input  logic                   relSplit2nd,
  input  logic                   blkSet,
  input  logic                   blkClr,
  input  logic [THREAD_W-1:0]    blkThread,
  input  trackLook_t             look,
  output trackStrb_t             strb,
  output logic                   reqGrant,
  output logic                   reqOverflow,
  output logic                   relMissErr,
  output logic [NUM_THREADS-1:0] blkState
);

  logic [NUM_THREADS-1:0] blkFlag;
  trackDec_e              dec;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rstN) begin
        blkFlag[t] <= 1'b0;
      end else if (blkSet && (blkThread == THREAD_W'(t))) begin
        blkFlag[t] <= 1'b1;
      end else if (blkClr && (blkThread == THREAD_W'(t))) begin
        blkFlag[t] <= 1'b0;
      end
    end
  end

  always_comb begin
    dec = DEC_IDLE;
    if (reqValid) begin
      if (blkFlag[reqThread]) begin
        dec = DEC_BLOCKED;
      end else if (!reqFetch && look.conflict) begin
        dec = look.ownerMatch ? DEC_REPLAY : DEC_CONFLICT;
      end else if (look.full) begin
        dec = DEC_FULL;
      end else begin
        dec = DEC_NEW;
      end
    end
  end

  assign reqGrant    = (dec == DEC_NEW) || (dec == DEC_REPLAY);
  assign reqOverflow = (dec == DEC_FULL);
  assign strb.insEn  = (dec == DEC_NEW);
  assign strb.relEn  = relValid && look.relHit;
  assign relMissErr  = relValid && !look.relHit && !relSplit2nd;
  assign blkState    = blkFlag;

  AST_BLOCKED_DENY: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |-> !blkFlag[reqThread]); // R4

  AST_BLK_SET: assert property (@(posedge clk) disable iff (!rstN)
    blkSet |=> blkFlag[$past(blkThread)]); // R4

  AST_CONFLICT_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant && !reqFetch && look.conflict) |-> look.ownerMatch); // R1

  AST_REPLAY_NO_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant && !reqFetch && look.conflict) |-> !strb.insEn); // R2

  AST_OVF_DENY: assert property (@(posedge clk) disable iff (!rstN)
    reqOverflow |-> !reqGrant); // R6

  AST_MISS_TOLERATED: assert property (@(posedge clk) disable iff (!rstN)
    relMissErr |-> (relValid && !relSplit2nd)); // R7

endmodule

// File: rtl/addr_track_top.sv
module addr_track_top
  import addr_track_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int LIST_LIMIT  = 10,
  parameter int ADDR_W      = 32,
  parameter int SEQ_W       = 16,
  localparam int THREAD_W   = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int DEPTH      = LIST_LIMIT - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [THREAD_W-1:0]    reqThread,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [SEQ_W-1:0]       reqSeq,
  input  logic                   reqFetch,
  output logic                   reqGrant,
  output logic                   reqOverflow,
  input  logic                   relValid,
  input  logic [THREAD_W-1:0]    relThread,
  input  logic [ADDR_W-1:0]      relAddr,
  input  logic                   relSplit2nd,
  output logic                   relMissErr,
  input  logic                   blkSet,
  input  logic                   blkClr,
  input  logic [THREAD_W-1:0]    blkThread,
  output logic [NUM_THREADS-1:0] blkState
);

  trackStrb_t strb;
  trackLook_t look;

  addr_track_store #(
    .NUM_THREADS(NUM_THREADS), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
    .SEQ_W(SEQ_W), .THREAD_W(THREAD_W)
  ) u_store (
    .clk(clk), .rstN(rstN),
    .reqThread(reqThread), .reqAddr(reqAddr), .reqSeq(reqSeq),
    .relValid(relValid), .relThread(relThread), .relAddr(relAddr),
    .strb(strb), .look(look)
  );

  addr_track_ctrl #(
    .NUM_THREADS(NUM_THREADS), .THREAD_W(THREAD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqThread(reqThread), .reqFetch(reqFetch),
    .relValid(relValid), .relSplit2nd(relSplit2nd),
    .blkSet(blkSet), .blkClr(blkClr), .blkThread(blkThread),
    .look(look), .strb(strb),
    .reqGrant(reqGrant), .reqOverflow(reqOverflow),
    .relMissErr(relMissErr), .blkState(blkState)
  );

endmodule

// File: tb/addr_track_top_bench.sv
module addr_track_top_bench;

  localparam int NT = 2;
  localparam int LIM = 4;
  localparam int AW = 16;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqFetch = 0, relValid = 0, relSplit2nd = 0;
  logic blkSet = 0, blkClr = 0;
  logic [0:0] reqThread = 0, relThread = 0, blkThread = 0;
  logic [AW-1:0] reqAddr = 0, relAddr = 0;
  logic [SW-1:0] reqSeq = 0;
  logic reqGrant, reqOverflow, relMissErr;
  logic [NT-1:0] blkState;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  addr_track_top #(.NUM_THREADS(NT), .LIST_LIMIT(LIM), .ADDR_W(AW), .SEQ_W(SW)) u_addr_track_top (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqThread(reqThread), .reqAddr(reqAddr), .reqSeq(reqSeq),
    .reqFetch(reqFetch), .reqGrant(reqGrant), .reqOverflow(reqOverflow),
    .relValid(relValid), .relThread(relThread), .relAddr(relAddr),
    .relSplit2nd(relSplit2nd), .relMissErr(relMissErr),
    .blkSet(blkSet), .blkClr(blkClr), .blkThread(blkThread), .blkState(blkState)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Present a request, check the answer, withdraw it before the edge.
  task automatic probe(input int t, input int a, input int s, input bit f,
                       input int expG, input int expO, input string tag);
    @(negedge clk);
    reqValid = 1; reqThread = t[0:0]; reqAddr = a[AW-1:0]; reqSeq = s[SW-1:0]; reqFetch = f;
    #1;
    check({tag, " grant"}, int'(reqGrant), expG);
    check({tag, " overflow"}, int'(reqOverflow), expO);
    reqValid = 0;
  endtask

  // Present a request and let it be committed at the edge.
  task automatic issue(input int t, input int a, input int s, input bit f,
                       input int expG, input string tag);
    @(negedge clk);
    reqValid = 1; reqThread = t[0:0]; reqAddr = a[AW-1:0]; reqSeq = s[SW-1:0]; reqFetch = f;
    #1;
    check({tag, " grant"}, int'(reqGrant), expG);
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic release_addr(input int t, input int a, input bit split,
                              input int expMiss, input string tag);
    @(negedge clk);
    relValid = 1; relThread = t[0:0]; relAddr = a[AW-1:0]; relSplit2nd = split;
    #1;
    check({tag, " miss"}, int'(relMissErr), expMiss);
    @(posedge clk); #1;
    relValid = 0; relSplit2nd = 0;
  endtask

  task automatic block_ctl(input bit s, input bit c, input int t);
    @(negedge clk);
    blkSet = s; blkClr = c; blkThread = t[0:0];
    @(posedge clk); #1;
    blkSet = 0; blkClr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1;
  endtask

  task automatic t_reset_state();
    @(negedge clk); #1;
    check("R9 blkState after reset", int'(blkState), 0);
    check("R9 no grant when idle", int'(reqGrant), 0);
    probe(0, 'h100, 1, 0, 1, 0, "R9 empty list grants");
  endtask

  task automatic t_conflict();
    issue(0, 'h100, 1, 0, 1, "R5 first insert");
    probe(0, 'h100, 2, 0, 0, 0, "R1 same thread same addr");
    probe(1, 'h100, 3, 0, 1, 0, "R1 other thread same addr");
    probe(0, 'h104, 2, 0, 1, 0, "R1 same thread other addr");
  endtask

  task automatic t_replay();
    issue(0, 'h100, 1, 0, 1, "R2 owner replay");
    release_addr(0, 'h100, 0, 0, "R2 single release");
    probe(0, 'h100, 2, 0, 1, 0, "R2 addr free after one release");
    release_addr(0, 'h100, 0, 1, "R2 no second entry");
  endtask

  task automatic t_fetch();
    issue(1, 'h200, 5, 1, 1, "R3 fetch first");
    issue(1, 'h200, 5, 1, 1, "R3 fetch duplicate");
    probe(1, 'h200, 6, 0, 0, 0, "R3 fetch entry recorded");
    release_addr(1, 'h200, 0, 0, "R3 release one");
    probe(1, 'h200, 6, 0, 0, 0, "R3 second entry remains");
    release_addr(1, 'h200, 0, 0, "R3 release two");
    probe(1, 'h200, 6, 0, 1, 0, "R3 list empty again");
  endtask

  task automatic t_overflow_and_order();
    issue(0, 'h10, 10, 0, 1, "R6 fill 1");
    issue(0, 'h20, 11, 0, 1, "R6 fill 2");
    issue(0, 'h30, 12, 0, 1, "R6 fill 3");
    probe(0, 'h40, 13, 0, 0, 1, "R6 full data");
    probe(0, 'h50, 14, 1, 0, 1, "R6 full fetch");
    probe(0, 'h10, 10, 0, 1, 0, "R6 replay when full");
    probe(1, 'h40, 13, 0, 1, 0, "R6 other thread free");
    // Same-cycle release and request of the same address.
    @(negedge clk);
    relValid = 1; relThread = 0; relAddr = 'h20; relSplit2nd = 0;
    reqValid = 1; reqThread = 0; reqAddr = 'h20; reqSeq = 15; reqFetch = 0;
    #1;
    check("R8 freed addr granted", int'(reqGrant), 1);
    check("R8 no overflow", int'(reqOverflow), 0);
    check("R8 release hit", int'(relMissErr), 0);
    @(posedge clk); #1;
    relValid = 0; reqValid = 0;
    probe(0, 'h20, 11, 0, 0, 0, "R8 new owner holds addr");
    probe(0, 'h40, 13, 0, 0, 1, "R8 list full again");
    release_addr(0, 'h10, 0, 0, "R7 drain 1");
    release_addr(0, 'h20, 0, 0, "R7 drain 2");
    release_addr(0, 'h30, 0, 0, "R7 drain 3");
  endtask

  task automatic t_release_miss();
    release_addr(0, 'h999, 0, 1, "R7 missing entry flagged");
    release_addr(0, 'h999, 1, 0, "R7 split second half tolerated");
  endtask

  task automatic t_block();
    block_ctl(1, 0, 1);
    check("R4 flag set", int'(blkState), 2);
    probe(1, 'h300, 1, 0, 0, 0, "R4 blocked data");
    probe(1, 'h304, 1, 1, 0, 0, "R4 blocked fetch");
    probe(0, 'h300, 1, 0, 1, 0, "R4 other thread open");
    block_ctl(1, 1, 1);
    check("R4 set wins", int'(blkState), 2);
    block_ctl(0, 1, 1);
    check("R4 flag cleared", int'(blkState), 0);
    probe(1, 'h300, 1, 0, 1, 0, "R4 unblocked grant");
  endtask

  task automatic t_reset_clears();
    issue(1, 'h400, 1, 0, 1, "R9 pre-reset insert");
    block_ctl(1, 0, 0);
    do_reset();
    #1;
    check("R9 flags cleared", int'(blkState), 0);
    probe(1, 'h400, 2, 0, 1, 0, "R9 list cleared");
    probe(0, 'h400, 2, 0, 1, 0, "R9 thread0 open");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_conflict();
    t_replay();
    t_fetch();
    t_overflow_and_order();
    t_release_miss();
    t_block();
    t_reset_clears();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule